// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM. The host presents a single request: an address, a write flag, write data and a request strobe. The controller turns that request into a correctly timed sequence on the memory pins. These pins are three active-low strobes (chip select, output enable and write strobe), an address bus, and a data bus that is split into an output value, an input value and a drive enable. When the transaction ends, the controller returns a one-cycle completion pulse. For a read, the byte it captured is returned alongside that pulse.

Every timing window is a clock-cycle count. Each count is derived when the block is elaborated from a table of nanosecond minimums, and a parameter selects which speed grade that table holds. Writes are closed by the write strobe. The pulse width, data setup, address-to-strobe-end and data hold are each enforced separately, and output enable is held high for the whole write. After every read, the controller waits a bus-turnaround window before it accepts the next request, so that the memory's drivers have released the data bus before the controller drives it.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: After reset and whenever no transaction is in progress, chip select, output enable and write strobe are high (1), the data drive enable is low and the completion pulse is low.
- R2: On the clock edge that accepts a read, chip select and output enable fall together and the request address appears on the address bus. The write strobe stays high for the whole read, and the address does not change while chip select is low.
- R3: A read samples the data input RD_CYC edges after the strobes fall, where RD_CYC = ceil(max(cycle time, address access, output-enable access) / clock period) with a minimum of 1. The sampled byte is presented on the read-data output and held there.
- R4: On a write, the write strobe and chip select stay low for exactly WR_CYC cycles, where WR_CYC is the largest of the cycle counts for pulse width, data setup and address-to-strobe-end, and of (cycle-time count minus HOLD_CYC). Output enable is high throughout, and the write strobe is never low while chip select is high.
- R5: The data bus is driven with the request's write data from the edge on which the write strobe falls, and address and data do not change while the strobe is low.
- R6: After the write strobe rises, address and write data stay driven and unchanged for HOLD_CYC = ceil(data hold / clock period) cycles, with chip select high.
- R7: After output enable rises at the end of a read, the controller does not drive the data bus for at least HIZ_CYC = ceil(output float time / clock period) cycles. Drive enable is never high while output enable is low.
- R8: A request is accepted only when the controller is idle. Changes to request, write flag, address or write data during a transaction have no effect on that transaction.
- R9: The completion pulse lasts one cycle. It rises RD_CYC+HIZ_CYC edges after a read is accepted, or WR_CYC+HOLD_CYC edges after a write is accepted. A request present during the cycle of the completion pulse is accepted on the next edge.
- R10: The speed-grade parameter selects the nanosecond set (0: the 70 ns grade, 1: the 150 ns grade, 2: the 200 ns grade). Each count is ceil(ns / CLK_PERIOD_NS) with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Last byte read |
| sramCeN | output | 1 | Memory chip select, active low |
| sramOeN | output | 1 | Memory output enable, active low |
| sramWeN | output | 1 | Memory write strobe, active low |
| sramAddr | output | ADDR_W | Memory address bus |
| sramDqOut | output | DATA_W | Value driven onto the data bus |
| sramDqOe | output | 1 | Data bus drive enable |
| sramDqIn | input | DATA_W | Value read from the data bus |

## Verification
Two functions share one cycle. The completion pulse of one transaction and the acceptance of the next fall in the same cycle, and after a read, the end of the turnaround window coincides with the first cycle a following write may drive the bus. The bench provokes both by keeping the request asserted across back-to-back read-after-write and write-after-read pairs. It then measures the cycle count between output enable rising and drive enable rising, and compares the transaction length against the counts it derives from the nanosecond table. The memory model returns the complement of the stored byte until its access window has elapsed, so a read that samples one edge early returns the wrong value.

// File: rtl/sram_cyc_pkg.sv
`timescale 1ns/1ps
package sram_cyc_pkg;

  typedef enum int {
    T_CYCLE, T_ADDR_ACC, T_OE_ACC, T_WE_PULSE,
    T_DATA_SETUP, T_ADDR_END, T_DATA_HOLD, T_FLOAT
  } timing_e;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic dqDrive;
    logic done;
    logic load;     // request accepted this edge
    logic capture;  // sample the data bus this edge
  } strobe_t;

  // Minimum nanoseconds per speed grade (0 fastest).
  function automatic int gradeNs(input int grade, input timing_e t);
    case (t)
      T_CYCLE:      return (grade == 2) ? 200 : (grade == 1) ? 150 : 70;
      T_ADDR_ACC:   return (grade == 2) ? 200 : (grade == 1) ? 150 : 70;
      T_OE_ACC:     return (grade == 2) ? 80  : (grade == 1) ? 75  : 35;
      T_WE_PULSE:   return (grade == 2) ? 120 : (grade == 1) ? 90  : 50;
      T_DATA_SETUP: return (grade == 2) ? 60  : (grade == 1) ? 40  : 30;
      T_ADDR_END:   return (grade == 2) ? 140 : (grade == 1) ? 120 : 60;
      T_DATA_HOLD:  return 5;
      T_FLOAT:      return (grade == 2) ? 40  : (grade == 1) ? 35  : 25;
      default:      return 1;
    endcase
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int nsToCyc(input int ns, input int periodNs);
    return maxOf(1, (ns + periodNs - 1) / periodNs);
  endfunction

endpackage

// File: rtl/sram_cyc_fsm.sv
`timescale 1ns/1ps
module sram_cyc_fsm
  import sram_cyc_pkg::*;
#(
  parameter int RD_CYC   = 7,
  parameter int HIZ_CYC  = 3,
  parameter int WR_CYC   = 6,
  parameter int HOLD_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output strobe_t stb
);

  localparam int MAXC = maxOf(maxOf(RD_CYC, HIZ_CYC), maxOf(WR_CYC, HOLD_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_TURN, S_WRITE, S_HOLD} state_e;

  state_e        state, stateNext;
  logic [CW-1:0] cnt, cntNext;
  logic          phaseEnd;
  logic          ceQ, oeQ, weQ, driveQ, doneQ;

  assign phaseEnd = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = phaseEnd ? cnt : cnt - CW'(1);
    case (state)
      S_IDLE: if (reqValid) begin
        stateNext = reqWrite ? S_WRITE : S_READ;
        cntNext   = reqWrite ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
      end
      S_READ: if (phaseEnd) begin
        stateNext = S_TURN;
        cntNext   = CW'(HIZ_CYC - 1);
      end
      S_WRITE: if (phaseEnd) begin
        stateNext = S_HOLD;
        cntNext   = CW'(HOLD_CYC - 1);
      end
      S_TURN, S_HOLD: if (phaseEnd) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      ceQ    <= 1'b1;
      oeQ    <= 1'b1;
      weQ    <= 1'b1;
      driveQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      ceQ    <= !(stateNext inside {S_READ, S_WRITE});
      oeQ    <= (stateNext != S_READ);
      weQ    <= (stateNext != S_WRITE);
      driveQ <= (stateNext inside {S_WRITE, S_HOLD});
      doneQ  <= (stateNext == S_IDLE) && (state != S_IDLE);
    end
  end

  always_comb begin
    stb.ceN     = ceQ;
    stb.oeN     = oeQ;
    stb.weN     = weQ;
    stb.dqDrive = driveQ;
    stb.done    = doneQ;
    stb.load    = (state == S_IDLE) && reqValid;
    stb.capture = (state == S_READ) && phaseEnd;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> (ceQ && oeQ && weQ && !driveQ));
  p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !weQ |-> oeQ);
  p_we_under_ce_r4: assert property (@(posedge clk) disable iff (!rstN)
    !weQ |-> !ceQ);
  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  p_busy_no_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ceQ || driveQ) |-> (state != S_IDLE));

endmodule

// File: rtl/sram_cyc_datapath.sv
`timescale 1ns/1ps
module sram_cyc_datapath
  import sram_cyc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdData   <= '0;
    end else begin
      if (stb.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (stb.capture) rdData <= sramDqIn;
    end
  end

  assign sramAddr  = addrReg;
  assign sramDqOut = wdataReg;
  assign sramDqOe  = stb.dqDrive;

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.ceN && $past(!stb.ceN)) |-> $stable(addrReg));
  p_no_drive_with_oe_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.dqDrive |-> stb.oeN);
  p_hold_after_we_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.weN) |-> (stb.dqDrive && $stable(wdataReg) && $stable(addrReg)));
  p_capture_while_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (!stb.oeN && !stb.ceN));
  p_load_only_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (stb.ceN && !stb.dqDrive));

endmodule

// File: rtl/sram_cyc_ctrl.sv
`timescale 1ns/1ps
module sram_cyc_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int CYC_NS   = gradeNs(SPEED_GRADE, T_CYCLE);
  localparam int RD_NS    = maxOf(CYC_NS, maxOf(gradeNs(SPEED_GRADE, T_ADDR_ACC),
                                                gradeNs(SPEED_GRADE, T_OE_ACC)));
  localparam int RD_CYC   = nsToCyc(RD_NS, CLK_PERIOD_NS);
  localparam int HIZ_CYC  = nsToCyc(gradeNs(SPEED_GRADE, T_FLOAT), CLK_PERIOD_NS);
  localparam int HOLD_CYC = nsToCyc(gradeNs(SPEED_GRADE, T_DATA_HOLD), CLK_PERIOD_NS);
  localparam int WR_CYC   = maxOf(
      maxOf(nsToCyc(gradeNs(SPEED_GRADE, T_WE_PULSE), CLK_PERIOD_NS),
            nsToCyc(gradeNs(SPEED_GRADE, T_DATA_SETUP), CLK_PERIOD_NS)),
      maxOf(nsToCyc(gradeNs(SPEED_GRADE, T_ADDR_END), CLK_PERIOD_NS),
            maxOf(1, nsToCyc(CYC_NS, CLK_PERIOD_NS) - HOLD_CYC)));

  strobe_t stb;

  sram_cyc_fsm #(
    .RD_CYC(RD_CYC), .HIZ_CYC(HIZ_CYC), .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .stb(stb)
  );

  sram_cyc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .sramDqIn(sramDqIn), .sramAddr(sramAddr), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe), .rdData(rspRdata)
  );

  assign rspDone = stb.done;
  assign sramCeN = stb.ceN;
  assign sramOeN = stb.oeN;
  assign sramWeN = stb.weN;

endmodule

// File: tb/test_sram_cyc_ctrl.sv
`timescale 1ns/1ps
module test_sram_cyc_ctrl;

  localparam int TCK = 10;
  function automatic int cdiv(input int ns);
    int c = (ns + TCK - 1) / TCK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // 70 ns grade, computed independently from the requirement text (R10)
  localparam int E_RD    = cdiv(mx(70, mx(70, 35)));
  localparam int E_VALID = mx(cdiv(70), cdiv(35));
  localparam int E_HIZ   = cdiv(25);
  localparam int E_HOLD  = cdiv(5);
  localparam int E_WR    = mx(mx(cdiv(50), cdiv(30)), mx(cdiv(60), mx(1, cdiv(70) - E_HOLD)));

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic       rspDone;
  logic [7:0] rspRdata;
  logic       sramCeN, sramOeN, sramWeN, sramDqOe;
  logic [10:0] sramAddr;
  logic [7:0] sramDqOut;
  logic [7:0] sramDqIn = '0;

  always #(TCK / 2) clk = ~clk;

  sram_cyc_ctrl i_sram_cyc_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspDone(rspDone), .rspRdata(rspRdata),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN), .sramAddr(sramAddr),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] model [2048];
  logic [7:0] expMem [2048];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model and bus monitor, evaluated away from the active edge
  int oeCnt = 0, weCnt = 0, sinceOe = 1000;
  logic [10:0] lastAddr = '0, pAddr = '0;
  logic [7:0] pData = '0;
  logic prevDone = 0, prevDqOe = 0;

  always @(negedge clk) if (rstN) begin
    chk(!(!sramWeN && !sramOeN), "R4 oe/we overlap", 1, 0);
    chk(!(!sramWeN && sramCeN), "R4 we without ce", 1, 0);
    chk(!(sramDqOe && !sramOeN), "R7 drive with oe", 1, 0);
    if (!sramCeN && oeCnt > 0) chk(sramAddr == lastAddr, "R2 addr stable", int'(sramAddr), int'(lastAddr));
    if (!sramCeN && !sramOeN) oeCnt = (oeCnt > 0 && sramAddr == lastAddr) ? oeCnt + 1 : 1;
    else oeCnt = 0;
    if (!sramCeN) lastAddr = sramAddr;
    sramDqIn <= (oeCnt >= E_VALID) ? model[sramAddr] : ~model[sramAddr];

    if (!sramWeN) begin
      weCnt++;
      chk(sramDqOe, "R5 data driven", int'(sramDqOe), 1);
      if (weCnt > 1) begin
        chk(sramDqOut == pData, "R5 data stable", int'(sramDqOut), int'(pData));
        chk(sramAddr == pAddr, "R5 addr stable", int'(sramAddr), int'(pAddr));
      end
      pData = sramDqOut;
      pAddr = sramAddr;
    end else if (weCnt > 0) begin
      chk(weCnt == E_WR, "R4 strobe width", weCnt, E_WR);
      chk(sramDqOe && sramDqOut == pData && sramAddr == pAddr && sramCeN,
          "R6 hold after strobe", int'(sramDqOut), int'(pData));
      model[pAddr] = pData;
      weCnt = 0;
    end

    if (!sramOeN) sinceOe = 0;
    else if (sinceOe < 1000) sinceOe++;
    if (sramDqOe && !prevDqOe) chk(sinceOe - 1 >= E_HIZ, "R7 turnaround", sinceOe - 1, E_HIZ);
    chk(!(rspDone && prevDone), "R9 done width", 1, 0);
    prevDone = rspDone;
    prevDqOe = sramDqOe;
  end

  // One transaction; called at a negedge, returns at the negedge of its done pulse.
  task automatic txn(input bit w, input int a, input logic [7:0] d, input bit keep);
    int cyc = 0;
    int expLen = w ? (E_WR + E_HOLD) : (E_RD + E_HIZ);
    reqValid = 1'b1; reqWrite = w; reqAddr = 11'(a); reqWdata = d;
    @(posedge clk);
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        chk(!sramCeN && sramAddr == 11'(a), "R2 strobes/address on accept", int'(sramAddr), a);
        if (w) chk(!sramWeN && sramOeN && sramDqOut == d, "R4 write start", int'(sramDqOut), int'(d));
        else   chk(!sramOeN && sramWeN, "R2 read start", int'(sramOeN), 0);
        // R8: disturb every request input while busy
        reqWrite = !w; reqAddr = ~11'(a); reqWdata = ~d;
      end
    end while (!rspDone && cyc < 100);
    chk(cyc == expLen + 1, "R9 latency", cyc - 1, expLen);
    if (w) expMem[a] = d;
    else chk(rspRdata == expMem[a], "R3 read data", int'(rspRdata), int'(expMem[a]));
    if (!keep) reqValid = 1'b0;
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chk(sramCeN && sramOeN && sramWeN && !sramDqOe && !rspDone, "R1 idle strobes",
        {sramCeN, sramOeN, sramWeN, sramDqOe, rspDone}, 5'b11100);
  endtask

  initial begin
    #(1_500_000);
    if (!finished) begin
      chk(0, "R9 watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 2048; a++) begin
      model[a]  = 8'(a * 7 + 3) ^ 8'(a >> 3);
      expMem[a] = 8'(a * 7 + 3) ^ 8'(a >> 3);
    end
    repeat (3) @(negedge clk);
    chk(sramCeN && sramOeN && sramWeN && !sramDqOe && !rspDone, "R1 reset state", int'(sramCeN), 1);
    rstN = 1'b1;
    idleCheck();

    // R3/R10: isolated reads, including both address extremes
    txn(0, 0, 8'h00, 0); idleCheck();
    txn(0, 2047, 8'h00, 0); idleCheck();
    for (int i = 0; i < 20; i++) begin txn(0, (i * 331 + 5) % 2048, 8'h00, 0); idleCheck(); end

    // R4/R5/R6: back-to-back writes (done and accept share a cycle, R9)
    for (int i = 0; i < 24; i++) txn(1, (i * 331 + 5) % 2048, 8'(i * 37 + 11), i != 23);
    txn(1, 0, 8'hA5, 1);
    txn(1, 2047, 8'h5A, 0);
    idleCheck();

    // R7: alternating write/read pairs with the request held high
    for (int i = 0; i < 16; i++) begin
      txn(1, (i * 97 + 1) % 2048, 8'(255 - i * 13), 1);
      txn(0, (i * 97 + 1) % 2048, 8'h00, 1);
    end
    txn(0, 0, 8'h00, 0);
    idleCheck();

    // R3: read back everything written
    for (int i = 0; i < 24; i++) txn(0, (i * 331 + 5) % 2048, 8'h00, 1);
    txn(0, 2047, 8'h00, 0);
    idleCheck();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule